// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses coming back from audio codecs and stores each one as an 8-byte record in a 256-slot ring in system memory. A response is a 32-bit payload plus the address of the codec that sent it and a flag that says whether the codec volunteered it (unsolicited) or answered a command (solicited). Responses first land in a small on-chip queue. A sequencer then drains the queue one record at a time. For each record it issues two 32-bit writes over a request/response memory port.

The sequencer keeps a hardware write pointer that always names the most recently written slot. For each record it first moves the pointer on by one, modulo 256, and then writes the record into that slot. The pointer register takes the new slot number once both writes have returned, even if one of them came back with an error. Errors are reported through one sticky overrun flag. The flag is set when a response arrives while the queue is full and has to be discarded. It is also set, when the overrun interrupt enable is on, when either memory write of a record fails. The interrupt line follows the flag, gated by the enable.

Software sees five registers through a simple write strobe and a combinational read port:

| Offset | Register | Contents |
|--------|----------|----------|
| 0 | base low | bits 31:0 of the ring base |
| 1 | base high | bits 63:32 of the ring base |
| 2 | control | bit 0 is the overrun interrupt enable |
| 3 | status | bit 0 is the overrun flag; writing 1 clears it |
| 4 | pointer | bits 7:0 read the write pointer; a write with bit 15 set forces the pointer to 0xFF |

The sequencer moves through named states. ST_IDLE goes to ST_ISSUE_LO when the queue holds an entry (transition "take"). ST_ISSUE_LO goes to ST_WAIT_LO when the memory port accepts the request ("lo accepted"). ST_WAIT_LO goes to ST_ISSUE_HI on the first response ("lo done"). ST_ISSUE_HI goes to ST_WAIT_HI on acceptance ("hi accepted"). ST_WAIT_HI goes to ST_COMMIT on the second response ("hi done"). ST_COMMIT always returns to ST_IDLE ("retire").

Top module: `rsp_ring_writer`

## Requirements
- R1: After reset the pointer register reads 0xFF, the status register reads 0, irq is low and no memory request is pending.
- R2: A record is written at slot (pointer + 1) mod 256. Its byte address is the 64-bit base {base high, base low} plus 8 times the slot, and every write address is 4-byte aligned.
- R3: The two writes of a record are issued in order: the payload at record offset 0, then the extended word at offset 4. The second is issued only after the first response, and an unaccepted request holds its address and data steady.
- R4: The extended word carries the codec address in bits 3:0, a 1 in bit 4 for an unsolicited response and a 0 for a solicited one, and zeros elsewhere.
- R5: Once both write responses of a record have returned, the pointer register holds that record's slot, also when a write failed. The pointer wraps from 0xFF to 0x00 and changes only by +1 or by the force control.
- R6: A failed write response sets the overrun flag only when the control enable bit is 1. With the enable at 0 the flag stays 0.
- R7: The queue holds 4 responses. A response that arrives while the queue is full is discarded (it is never written) and sets the overrun flag whatever the enable bit says.
- R8: The overrun flag is sticky. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R9: irq is high exactly when the overrun flag and the enable bit are both 1.
- R10: Writing the pointer register with bit 15 set forces the pointer to 0xFF, so the next record lands in slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_valid | input | 1 | A codec response is present this cycle |
| rsp_payload | input | 32 | Response payload |
| rsp_cad | input | 4 | Codec address of the sender |
| rsp_unsol | input | 1 | 1 = unsolicited response |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_addr | output | 64 | Byte address of the 32-bit write |
| mem_req_data | output | 32 | Little-endian write data |
| mem_rsp_valid | input | 1 | Write response strobe |
| mem_rsp_err | input | 1 | Write response reports failure |
| irq | output | 1 | Overrun interrupt request |

## Verification
The bound checker watches several properties on every cycle. It checks that a stalled request keeps its address and data, that write addresses are aligned, and that the pointer moves only by one step or by the force control. It also checks that a discard leaves the flag set, that the flag holds until a write-one clear, and that irq never rises without both the flag and the enable. Other behaviours need a memory model that logs the writes, so only the directed scenarios show them. These are the exact slot addresses and write order, the contents of the extended word, the wrap of the ring from slot 255 to slot 0, and which responses survive a queue overflow. The scenarios also show that error reporting depends on the enable and that the pointer advances past a failed write.

// File: rtl/rrw_pkg.sv
package rrw_pkg;

    localparam int PAYLOAD_W = 32;
    localparam int CAD_W     = 4;
    localparam int UNSOL_BIT = 4;

    // register offsets
    localparam logic [2:0] RG_BASE_LO = 3'd0;
    localparam logic [2:0] RG_BASE_HI = 3'd1;
    localparam logic [2:0] RG_CTRL    = 3'd2;
    localparam logic [2:0] RG_STAT    = 3'd3;
    localparam logic [2:0] RG_WPTR    = 3'd4;

    localparam int WPTR_FORCE_BIT = 15;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic [CAD_W-1:0]     cad;
        logic                 unsol;
    } rrw_rsp_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_LO,
        ST_WAIT_LO,
        ST_ISSUE_HI,
        ST_WAIT_HI,
        ST_COMMIT
    } rrw_state_e;

endpackage

// File: rtl/rrw_fifo.sv
module rrw_fifo #(
    parameter int WIDTH = 37,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             do_push, do_pop;

    assign full     = (count_q == CNT_W'(DEPTH));
    assign empty    = (count_q == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = store_q[rd_ptr_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            store_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/rrw_regs.sv
module rrw_regs #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int WP_W   = 8,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [WP_W-1:0]   wp_now,
    input  logic              drop_evt,
    input  logic              mem_fail_evt,
    output logic [ADDR_W-1:0] ring_base,
    output logic              ovr_ie,
    output logic              ovr_stat,
    output logic              wp_force,
    output logic              irq
);
    import rrw_pkg::*;

    logic [DATA_W-1:0] base_lo_q, base_hi_q;
    logic              ie_q, stat_q;
    logic              wr_lo, wr_hi, wr_ctrl, wr_stat, wr_wptr;
    logic              clr_req, set_req;

    assign wr_lo   = reg_wr_en && (reg_addr == REG_AW'(RG_BASE_LO));
    assign wr_hi   = reg_wr_en && (reg_addr == REG_AW'(RG_BASE_HI));
    assign wr_ctrl = reg_wr_en && (reg_addr == REG_AW'(RG_CTRL));
    assign wr_stat = reg_wr_en && (reg_addr == REG_AW'(RG_STAT));
    assign wr_wptr = reg_wr_en && (reg_addr == REG_AW'(RG_WPTR));

    assign clr_req  = wr_stat && reg_wdata[0];
    assign set_req  = drop_evt || (mem_fail_evt && ie_q);
    assign wp_force = wr_wptr && reg_wdata[WPTR_FORCE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            ie_q      <= 1'b0;
            stat_q    <= 1'b0;
        end else begin
            if (wr_lo)   base_lo_q <= reg_wdata;
            if (wr_hi)   base_hi_q <= reg_wdata;
            if (wr_ctrl) ie_q      <= reg_wdata[0];
            // a new event in the clearing cycle wins
            stat_q <= set_req || (stat_q && !clr_req);
        end
    end

    assign ring_base = ADDR_W'({base_hi_q, base_lo_q});
    assign ovr_ie    = ie_q;
    assign ovr_stat  = stat_q;
    assign irq       = stat_q && ie_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_AW'(RG_BASE_LO): reg_rdata = base_lo_q;
            REG_AW'(RG_BASE_HI): reg_rdata = base_hi_q;
            REG_AW'(RG_CTRL):    reg_rdata[0] = ie_q;
            REG_AW'(RG_STAT):    reg_rdata[0] = stat_q;
            REG_AW'(RG_WPTR):    reg_rdata[WP_W-1:0] = wp_now;
            default:             reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rrw_engine.sv
module rrw_engine #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int WP_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               head_valid,
    input  rrw_pkg::rrw_rsp_t  head,
    output logic               head_pop,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               wp_force,
    output logic [WP_W-1:0]    wp_now,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    output logic [DATA_W-1:0]  mem_req_data,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    output logic               fail_evt
);
    import rrw_pkg::*;

    localparam int ENTRY_SHIFT = 3;
    localparam logic [ADDR_W-1:0] HI_OFFSET = ADDR_W'(4);

    rrw_state_e        state_q, state_nx;
    rrw_rsp_t          cur_q;
    logic [WP_W-1:0]   wp_q, slot_q;
    logic              err_q;
    logic [ADDR_W-1:0] slot_addr;
    logic [DATA_W-1:0] ext_word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (head_valid)    state_nx = ST_ISSUE_LO;
            ST_ISSUE_LO: if (mem_req_ready) state_nx = ST_WAIT_LO;
            ST_WAIT_LO:  if (mem_rsp_valid) state_nx = ST_ISSUE_HI;
            ST_ISSUE_HI: if (mem_req_ready) state_nx = ST_WAIT_HI;
            ST_WAIT_HI:  if (mem_rsp_valid) state_nx = ST_COMMIT;
            ST_COMMIT:                      state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    // record datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '1;
            slot_q <= '0;
            cur_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wp_force)                    wp_q <= '1;
            else if (state_q == ST_COMMIT)   wp_q <= slot_q;

            if (state_q == ST_IDLE && head_valid) begin
                cur_q  <= head;
                slot_q <= wp_q + 1'b1;
                err_q  <= 1'b0;
            end else if ((state_q == ST_WAIT_LO || state_q == ST_WAIT_HI)
                         && mem_rsp_valid) begin
                err_q  <= err_q || mem_rsp_err;
            end
        end
    end

    always_comb begin
        ext_word = '0;
        ext_word[CAD_W-1:0] = cur_q.cad;
        ext_word[UNSOL_BIT] = cur_q.unsol;
    end

    assign slot_addr = ring_base + (ADDR_W'(slot_q) << ENTRY_SHIFT);

    // outputs
    always_comb begin
        head_pop      = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = slot_addr;
        mem_req_data  = cur_q.payload;
        fail_evt      = 1'b0;
        unique case (state_q)
            ST_IDLE:     head_pop = head_valid;
            ST_ISSUE_LO: mem_req_valid = 1'b1;
            ST_ISSUE_HI: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = slot_addr + HI_OFFSET;
                mem_req_data  = ext_word;
            end
            ST_COMMIT:   fail_evt = err_q;
            default:     ;
        endcase
    end

    assign wp_now = wp_q;

endmodule

// File: rtl/rsp_ring_writer.sv
module rsp_ring_writer #(
    parameter int ADDR_W     = 64,
    parameter int DATA_W     = 32,
    parameter int CAD_W      = 4,
    parameter int WP_W       = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int REG_AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_payload,
    input  logic [CAD_W-1:0]  rsp_cad,
    input  logic              rsp_unsol,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              irq
);
    import rrw_pkg::*;

    localparam int ENT_W = $bits(rrw_rsp_t);

    rrw_rsp_t          in_ent, head_ent;
    logic [ENT_W-1:0]  head_bits;
    logic              q_empty, q_full, q_pop;
    logic              drop_evt, fail_evt, wp_force;
    logic              ovr_ie, ovr_stat;
    logic [ADDR_W-1:0] ring_base;
    logic [WP_W-1:0]   wp_now;

    assign in_ent.payload = rsp_payload;
    assign in_ent.cad     = rsp_cad;
    assign in_ent.unsol   = rsp_unsol;
    assign drop_evt       = rsp_valid && q_full;
    assign head_ent       = rrw_rsp_t'(head_bits);

    rrw_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_valid),
        .push_data (in_ent),
        .pop       (q_pop),
        .pop_data  (head_bits),
        .empty     (q_empty),
        .full      (q_full)
    );

    rrw_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_W(WP_W)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .head_valid    (!q_empty),
        .head          (head_ent),
        .head_pop      (q_pop),
        .ring_base     (ring_base),
        .wp_force      (wp_force),
        .wp_now        (wp_now),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .fail_evt      (fail_evt)
    );

    rrw_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_W(WP_W), .REG_AW(REG_AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .wp_now       (wp_now),
        .drop_evt     (drop_evt),
        .mem_fail_evt (fail_evt),
        .ring_base    (ring_base),
        .ovr_ie       (ovr_ie),
        .ovr_stat     (ovr_stat),
        .wp_force     (wp_force),
        .irq          (irq)
    );

endmodule

// File: rtl/rrw_checker.sv
module rrw_checker #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 32,
    parameter int WP_W   = 8,
    parameter int REG_AW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_data,
    input logic              irq,
    input logic              ovr_stat,
    input logic              ovr_ie,
    input logic              drop_evt,
    input logic [WP_W-1:0]   wp_now
);
    import rrw_pkg::*;

    logic clr_wr, force_wr;
    assign clr_wr   = reg_wr_en && (reg_addr == REG_AW'(RG_STAT)) && reg_wdata[0];
    assign force_wr = reg_wr_en && (reg_addr == REG_AW'(RG_WPTR)) && reg_wdata[WPTR_FORCE_BIT];

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data));

    p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    p_wp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !force_wr |=> (wp_now == $past(wp_now)) || (wp_now == WP_W'($past(wp_now) + 1'b1)));

    p_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        force_wr |=> wp_now == '1);

    p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> ovr_stat);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_stat && !clr_wr |=> ovr_stat);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovr_stat && ovr_ie);

endmodule

bind rsp_ring_writer rrw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_W(WP_W), .REG_AW(REG_AW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_data  (mem_req_data),
    .irq           (irq),
    .ovr_stat      (ovr_stat),
    .ovr_ie        (ovr_ie),
    .drop_evt      (drop_evt),
    .wp_now        (wp_now)
);

// File: tb/rsp_ring_writer_bench.sv
module rsp_ring_writer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_payload = '0;
    logic [3:0]  rsp_cad = '0;
    logic        rsp_unsol = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic [31:0] mem_req_data;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic        irq;

    localparam logic [63:0] BASE = 64'h0000_0002_1000_0000;

    int          total = 0;
    int          bad = 0;
    int          wr_cnt = 0;
    int          err_at = -1;
    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [7:0]  exp_wp = 8'hFF;

    always #10 clk = ~clk;

    rsp_ring_writer u_rsp_ring_writer (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_payload(rsp_payload), .rsp_cad(rsp_cad),
        .rsp_unsol(rsp_unsol),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .irq(irq)
    );

    // memory model: logs accepted writes, answers one cycle later
    initial begin
        bit pend = 0;
        int pend_idx = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = (pend_idx == err_at);
                pend = 0;
            end
            if (rst_n && mem_req_valid && mem_req_ready) begin
                log_addr[wr_cnt % 64] = mem_req_addr;
                log_data[wr_cnt % 64] = mem_req_data;
                pend_idx = wr_cnt;
                pend = 1;
                wr_cnt++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [31:0] d, input logic [3:0] c, input logic u);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_payload = d; rsp_cad = c; rsp_unsol = u;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic wait_writes(input int n);
        int t = 0;
        while (wr_cnt < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (wr_cnt < n) chk("R3", "write count", 64'(wr_cnt), 64'(n));
        repeat (4) @(negedge clk);
    endtask

    // checks the two logged writes of one record
    task automatic chk_entry(input string req, input int first, input logic [7:0] slot,
                             input logic [31:0] pay, input logic [3:0] cad, input logic u);
        chk(req, "lo addr", log_addr[first % 64], BASE + 64'(slot) * 8);
        chk(req, "lo data", 64'(log_data[first % 64]), 64'(pay));
        chk(req, "hi addr", log_addr[(first + 1) % 64], BASE + 64'(slot) * 8 + 4);
        chk(req, "hi data", 64'(log_data[(first + 1) % 64]), {59'd0, u, cad});
    endtask

    task automatic one_record(input string req, input logic [31:0] pay,
                              input logic [3:0] cad, input logic u);
        int first = wr_cnt;
        logic [31:0] r;
        exp_wp = exp_wp + 8'd1;
        send(pay, cad, u);
        wait_writes(first + 2);
        chk_entry(req, first, exp_wp, pay, cad, u);
        reg_rd(3'd4, r);
        chk("R5", "pointer after record", 64'(r[7:0]), 64'(exp_wp));
    endtask

    task automatic t_reset;
        logic [31:0] r;
        reg_rd(3'd4, r);
        chk("R1", "pointer at reset", 64'(r), 64'h0000_00FF);
        reg_rd(3'd3, r);
        chk("R1", "status at reset", 64'(r), 64'd0);
        chk("R1", "irq at reset", 64'(irq), 64'd0);
        chk("R1", "no request at reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_basic;
        reg_wr(3'd0, BASE[31:0]);
        reg_wr(3'd1, BASE[63:32]);
        one_record("R2", 32'hCAFE_BABE, 4'h3, 1'b0);   // slot 0, solicited
        one_record("R4", 32'h1234_5678, 4'hA, 1'b1);   // slot 1, unsolicited
    endtask

    task automatic t_err_masked;
        logic [31:0] r;
        reg_wr(3'd2, 32'd0);
        err_at = wr_cnt;                               // payload write fails
        one_record("R5", 32'h0BAD_0001, 4'h1, 1'b0);
        reg_rd(3'd3, r);
        chk("R6", "flag with enable off", 64'(r), 64'd0);
        chk("R9", "irq with enable off", 64'(irq), 64'd0);
    endtask

    task automatic t_err_enabled;
        logic [31:0] r;
        reg_wr(3'd2, 32'd1);
        err_at = wr_cnt + 1;                           // extended write fails
        one_record("R5", 32'h0BAD_0002, 4'h2, 1'b1);
        reg_rd(3'd3, r);
        chk("R6", "flag with enable on", 64'(r), 64'd1);
        chk("R9", "irq raised", 64'(irq), 64'd1);
        reg_wr(3'd3, 32'd0);
        reg_rd(3'd3, r);
        chk("R8", "write 0 keeps flag", 64'(r), 64'd1);
        reg_wr(3'd2, 32'd0);
        chk("R9", "irq gated by enable", 64'(irq), 64'd0);
        reg_wr(3'd2, 32'd1);
        chk("R9", "irq back with enable", 64'(irq), 64'd1);
        reg_wr(3'd3, 32'd1);
        reg_rd(3'd3, r);
        chk("R8", "write 1 clears flag", 64'(r), 64'd0);
        chk("R9", "irq after clear", 64'(irq), 64'd0);
        err_at = -1;
    endtask

    task automatic t_overflow;
        logic [31:0] r;
        int first;
        reg_wr(3'd2, 32'd0);
        first = wr_cnt;
        @(posedge clk); #2 mem_req_ready = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rsp_valid = 1'b1; rsp_payload = 32'hF00D_0000 + i; rsp_cad = 4'(i); rsp_unsol = 1'b0;
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        reg_rd(3'd3, r);
        chk("R7", "flag after discard, enable off", 64'(r), 64'd1);
        @(posedge clk); #2 mem_req_ready = 1'b1;
        wait_writes(first + 10);
        repeat (20) @(negedge clk);
        chk("R7", "discarded response not written", 64'(wr_cnt), 64'(first + 10));
        for (int i = 0; i < 5; i++) begin
            exp_wp = exp_wp + 8'd1;
            chk_entry("R7", first + 2 * i, exp_wp, 32'hF00D_0000 + i, 4'(i), 1'b0);
        end
        reg_rd(3'd4, r);
        chk("R5", "pointer after burst", 64'(r[7:0]), 64'(exp_wp));
        reg_wr(3'd3, 32'd1);
    endtask

    task automatic t_wrap;
        while (exp_wp != 8'hFE) begin
            exp_wp = exp_wp + 8'd1;
            send(32'h5A5A_0000 + 32'(exp_wp), 4'h5, 1'b0);
            wait_writes(wr_cnt + 2);
        end
        one_record("R5", 32'hEEEE_00FF, 4'h6, 1'b1);   // slot 255
        one_record("R5", 32'hEEEE_0000, 4'h7, 1'b0);   // wraps to slot 0
    endtask

    task automatic t_force;
        logic [31:0] r;
        one_record("R2", 32'h7777_0001, 4'h8, 1'b0);   // slot 1
        reg_wr(3'd4, 32'h0000_8000);
        reg_rd(3'd4, r);
        chk("R10", "pointer forced", 64'(r[7:0]), 64'h00FF);
        exp_wp = 8'hFF;
        one_record("R10", 32'h7777_0002, 4'h9, 1'b1);  // lands in slot 0
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_err_masked();
        t_err_enabled();
        t_overflow();
        t_wrap();
        t_force();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule